// File: doc/BRIEF.md
# Indexed System Configuration Register Bank

This block holds the configuration bytes of a small system controller for an 8-bit-bus PC-class machine. The CPU reaches the bank indirectly: it first writes a register number to an index port, and then makes exactly one read or write on a data port. Each index write allows a single data-port access. Any further data-port access before the next index write is ignored, and a read returns all ones. Each register applies its own write mask and has its own reset value.

Besides the indexed bank, the block exports a 32-bit replacement NMI vector built from four of the bytes, together with its enable bit. It sends a one-cycle strobe to the memory mapper when the mapping register is written. It also holds three directly addressed I/O registers. A write to one of them can request a software reset. That request needs a bit in a control register and a bit in the written value to be set together. The reset returns the whole bank to its power-on state. Clock switching, CPU-type selection and the memory mapping itself sit outside this block, which only exports the values.

Top module: `xt_cfg_bank_top`

## Requirements
- R1: A write to port 0x22 stores the byte as the index and arms a one-shot access flag. A read of port 0x22 returns the stored index.
- R2: A read or write on port 0x23 takes effect only while the flag is armed. Every access to port 0x23 clears the flag. A later data-port write changes nothing, and a later data-port read returns 0xFF.
- R3: The implemented indices are 0x40 to 0x49, 0x4B and 0x4C. A data-port read of any other index returns 0xFF, and a data-port write to any other index changes no register.
- R4: Writes are masked: index 0x40 keeps value & 0xC7, index 0x41 keeps value & 0xED, and index 0x42 keeps value & 0x01. All other implemented indices store the full byte.
- R5: After reset the index is 0x00 and the flag is clear. Index 0x40 holds 0x01, index 0x43 holds 0x30 and index 0x48 holds 0x01. Every other register, including ports 0x72, 0x7E and 0x7F, holds 0x00.
- R6: `nmi_vec_o` is {idx 0x47, 0x46, 0x45, 0x44}, so index 0x44 is the least significant byte. `nmi_vec_en_o` equals bit 6 of index 0x4B.
- R7: Port 0x72 stores value & 0x7E. Ports 0x7E and 0x7F store the full byte. All three read back their stored values.
- R8: A write to port 0x7F with bit 3 set, while bit 6 of index 0x41 is 1, raises `swrst_o` for exactly one cycle and returns every register, the index and the flag to the R5 state. With bit 6 of index 0x41 at 0, no pulse occurs and the value is simply stored.
- R9: An accepted data-port write to index 0x4C raises `map_upd_o` for exactly one cycle.
- R10: Read data and `io_rvalid_o` are registered and appear in the cycle after the read strobe. `io_rvalid_o` is high only for reads of ports 0x22, 0x23, 0x72, 0x7E and 0x7F.
- R11: Byte k of `cfg_o` (bits 8k+7:8k) is the register at index 0x40+k. Byte 10 (index 0x4A) is always 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | Single-cycle write strobe |
| io_rd_i | input | 1 | Single-cycle read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |
| io_rvalid_o | output | 1 | Read data valid, one cycle after a decoded read |
| cfg_o | output | 104 | Indexed registers 0x40..0x4C, one byte each |
| nmi_vec_o | output | 32 | Replacement NMI vector |
| nmi_vec_en_o | output | 1 | NMI vector enable |
| map_upd_o | output | 1 | Mapping register update strobe |
| swrst_o | output | 1 | Software reset pulse |

## Verification
The bench targets the one-shot flag. A design that left the flag armed would accept a second data write, or return a register instead of 0xFF on a repeated read. It also probes the hole at 0x4A and indices outside the bank, where a loose decode would alias a real register. Writes of 0xFF expose wrong masks on 0x40 to 0x42 and 0x72. The software reset is tried both with and without its enable bit. A design that ignored the enable, or that kept the freshly written 0x7F value after the reset, shows up in the read-back that follows.

// File: rtl/xt_cfg_pkg.sv
package xt_cfg_pkg;

  typedef struct packed {
    logic idx;
    logic dat;
    logic p72;
    logic p7e;
    logic p7f;
  } port_sel_t;

  localparam int unsigned HOLE_SLOT = 10;

  function automatic logic [7:0] slot_mask(int unsigned s);
    case (s)
      0:         return 8'hC7;
      1:         return 8'hED;
      2:         return 8'h01;
      HOLE_SLOT: return 8'h00;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] slot_default(int unsigned s);
    case (s)
      0:       return 8'h01;
      3:       return 8'h30;
      8:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic slot_impl(int unsigned s);
    return s != HOLE_SLOT;
  endfunction

endpackage

// File: rtl/xt_cfg_decode.sv
module xt_cfg_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter logic [ADDR_W-1:0] P72_PORT = 'h72,
  parameter logic [ADDR_W-1:0] P7E_PORT = 'h7E,
  parameter logic [ADDR_W-1:0] P7F_PORT = 'h7F
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output xt_cfg_pkg::port_sel_t sel_o
);
  always_comb begin
    sel_o.idx = (addr_i == IDX_PORT);
    sel_o.dat = (addr_i == DAT_PORT);
    sel_o.p72 = (addr_i == P72_PORT);
    sel_o.p7e = (addr_i == P7E_PORT);
    sel_o.p7f = (addr_i == P7F_PORT);
  end
endmodule

// File: rtl/xt_cfg_regs.sv
module xt_cfg_regs #(
  parameter int          NREG     = 13,
  parameter logic [7:0]  BASE_IDX = 8'h40,
  parameter int unsigned UPD_SLOT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              idx_wr_i,
  input  logic              dat_wr_i,
  input  logic              dat_rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        idx_o,
  output logic [7:0]        dat_rval_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic              upd_o
);
  import xt_cfg_pkg::*;

  localparam logic [7:0] LAST_IDX = BASE_IDX + 8'(NREG - 1);

  logic       armed_q;
  logic [7:0] idx_q;
  logic [7:0] slot;
  logic       in_bank;
  logic       wr_ok;
  logic       upd_q;
  logic [NREG-1:0][7:0] regs;

  assign in_bank = (idx_q >= BASE_IDX) && (idx_q <= LAST_IDX);
  assign slot    = idx_q - BASE_IDX;
  assign wr_ok   = dat_wr_i && armed_q && in_bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      armed_q <= 1'b0;
    end else if (soft_clr_i) begin
      idx_q   <= '0;
      armed_q <= 1'b0;
    end else if (idx_wr_i) begin
      idx_q   <= wdata_i;
      armed_q <= 1'b1;
    end else if (dat_wr_i || dat_rd_i) begin
      armed_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : gen_slot
    localparam logic [7:0] MASK = slot_mask(k);
    localparam logic [7:0] DFLT = slot_default(k);
    logic [7:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      r_q <= DFLT;
      else if (soft_clr_i)              r_q <= DFLT;
      else if (wr_ok && slot == 8'(k))  r_q <= wdata_i & MASK;
    end
    assign regs[k] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         upd_q <= 1'b0;
    else if (soft_clr_i) upd_q <= 1'b0;
    else                 upd_q <= wr_ok && (slot == 8'(UPD_SLOT));
  end

  always_comb begin
    dat_rval_o = 8'hFF;
    for (int k = 0; k < NREG; k++) begin
      if (armed_q && in_bank && slot == 8'(k) && slot_impl(k)) dat_rval_o = regs[k];
    end
  end

  assign idx_o = idx_q;
  assign cfg_o = regs;
  assign upd_o = upd_q;
endmodule

// File: rtl/xt_cfg_aux.sv
module xt_cfg_aux #(
  parameter logic [7:0] P72_MASK = 8'h7E,
  parameter int         RST_BIT  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr72_i,
  input  logic       wr7e_i,
  input  logic       wr7f_i,
  input  logic [7:0] wdata_i,
  input  logic       rst_en_i,
  output logic [7:0] p72_o,
  output logic [7:0] p7e_o,
  output logic [7:0] p7f_o,
  output logic       soft_clr_o,
  output logic       swrst_o
);
  logic [7:0] p72_q, p7e_q, p7f_q;
  logic       sw_q;

  assign soft_clr_o = wr7f_i && wdata_i[RST_BIT] && rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p72_q <= '0;
      p7e_q <= '0;
      p7f_q <= '0;
      sw_q  <= 1'b0;
    end else begin
      sw_q <= soft_clr_o;
      if (soft_clr_o) begin
        p72_q <= '0;
        p7e_q <= '0;
        p7f_q <= '0;
      end else begin
        if (wr72_i) p72_q <= wdata_i & P72_MASK;
        if (wr7e_i) p7e_q <= wdata_i;
        if (wr7f_i) p7f_q <= wdata_i;
      end
    end
  end

  assign p72_o   = p72_q;
  assign p7e_o   = p7e_q;
  assign p7f_o   = p7f_q;
  assign swrst_o = sw_q;
endmodule

// File: rtl/xt_cfg_bank_top.sv
module xt_cfg_bank_top #(
  parameter int         ADDR_W   = 16,
  parameter int         NREG     = 13,
  parameter logic [7:0] BASE_IDX = 8'h40,
  parameter int         NMI_LO   = 4,
  parameter int         NMI_EN_SLOT = 11,
  parameter int         NMI_EN_BIT  = 6,
  parameter int         CTL_SLOT = 1,
  parameter int         CTL_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_rvalid_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic [31:0]       nmi_vec_o,
  output logic              nmi_vec_en_o,
  output logic              map_upd_o,
  output logic              swrst_o
);
  import xt_cfg_pkg::*;

  port_sel_t  sel;
  logic       soft_clr;
  logic [7:0] idx, dat_rval, p72, p7e, p7f;
  logic [7:0] rdata_q;
  logic       rvalid_q;

  xt_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (io_addr_i),
    .sel_o  (sel)
  );

  xt_cfg_regs #(.NREG(NREG), .BASE_IDX(BASE_IDX), .UPD_SLOT(NREG - 1)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_clr),
    .idx_wr_i   (io_wr_i && sel.idx),
    .dat_wr_i   (io_wr_i && sel.dat),
    .dat_rd_i   (io_rd_i && sel.dat),
    .wdata_i    (io_wdata_i),
    .idx_o      (idx),
    .dat_rval_o (dat_rval),
    .cfg_o      (cfg_o),
    .upd_o      (map_upd_o)
  );

  xt_cfg_aux u_aux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr72_i     (io_wr_i && sel.p72),
    .wr7e_i     (io_wr_i && sel.p7e),
    .wr7f_i     (io_wr_i && sel.p7f),
    .wdata_i    (io_wdata_i),
    .rst_en_i   (cfg_o[CTL_SLOT*8 + CTL_BIT]),
    .p72_o      (p72),
    .p7e_o      (p7e),
    .p7f_o      (p7f),
    .soft_clr_o (soft_clr),
    .swrst_o    (swrst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= io_rd_i && (|sel);
      unique case (1'b1)
        sel.idx: rdata_q <= idx;
        sel.dat: rdata_q <= dat_rval;
        sel.p72: rdata_q <= p72;
        sel.p7e: rdata_q <= p7e;
        sel.p7f: rdata_q <= p7f;
        default: rdata_q <= 8'hFF;
      endcase
    end
  end

  assign io_rdata_o   = rdata_q;
  assign io_rvalid_o  = rvalid_q;
  assign nmi_vec_o    = cfg_o[NMI_LO*8 +: 32];
  assign nmi_vec_en_o = cfg_o[NMI_EN_SLOT*8 + NMI_EN_BIT];
endmodule

// File: rtl/xt_cfg_chk.sv
module xt_cfg_chk #(
  parameter int ADDR_W = 16,
  parameter int NREG   = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_rdata_o,
  input logic              io_rvalid_o,
  input logic [NREG*8-1:0] cfg_o,
  input logic [31:0]       nmi_vec_o,
  input logic              nmi_vec_en_o,
  input logic              map_upd_o,
  input logic              swrst_o
);
  logic port_hit;
  assign port_hit = (io_addr_i == 'h22) || (io_addr_i == 'h23) || (io_addr_i == 'h72) ||
                    (io_addr_i == 'h7E) || (io_addr_i == 'h7F);

  AST_REPEAT_READ_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(io_rd_i && io_addr_i == 'h23) && $past(io_rd_i && io_addr_i == 'h23, 2))
      |-> (io_rvalid_o && io_rdata_o == 8'hFF)); // R2
  AST_SWRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |=> !swrst_o); // R8
  AST_SWRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |-> (!nmi_vec_en_o && nmi_vec_o == 32'h0 && cfg_o[7:0] == 8'h01)); // R8
  AST_SWRST_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |-> $past(io_wr_i && io_addr_i == 'h7F)); // R8
  AST_UPD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_upd_o |-> $past(io_wr_i && io_addr_i == 'h23)); // R9
  AST_RVALID_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rvalid_o |-> $past(io_rd_i)); // R10
  AST_UNDECODED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !port_hit) |=> !io_rvalid_o); // R10
  AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(io_wr_i) |-> cfg_o[87:80] == 8'h00); // R11
endmodule

bind xt_cfg_bank_top xt_cfg_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .io_addr_i    (io_addr_i),
  .io_wr_i      (io_wr_i),
  .io_rd_i      (io_rd_i),
  .io_rdata_o   (io_rdata_o),
  .io_rvalid_o  (io_rvalid_o),
  .cfg_o        (cfg_o),
  .nmi_vec_o    (nmi_vec_o),
  .nmi_vec_en_o (nmi_vec_en_o),
  .map_upd_o    (map_upd_o),
  .swrst_o      (swrst_o)
);

// File: tb/tb_xt_cfg_bank_top.sv
module tb_xt_cfg_bank_top;
  localparam int NREG = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o;
  logic        io_rvalid_o;
  logic [NREG*8-1:0] cfg_o;
  logic [31:0] nmi_vec_o;
  logic        nmi_vec_en_o;
  logic        map_upd_o;
  logic        swrst_o;

  int vectors = 0;
  int fails = 0;

  logic [7:0] m_reg [NREG];
  logic [7:0] m_idx, m_72, m_7e, m_7f;
  logic       m_arm;

  always #10 clk_i = ~clk_i;

  xt_cfg_bank_top dut (.*);

  function automatic logic [7:0] f_mask(int s);
    case (s)
      0: return 8'hC7;
      1: return 8'hED;
      2: return 8'h01;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic f_impl(logic [7:0] ix);
    return ix >= 8'h40 && ix <= 8'h4C && ix != 8'h4A;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NREG; k++) m_reg[k] = 8'h00;
    m_reg[0] = 8'h01; m_reg[3] = 8'h30; m_reg[8] = 8'h01;
    m_idx = 8'h00; m_arm = 1'b0;
    m_72 = 8'h00; m_7e = 8'h00; m_7f = 8'h00;
  endtask

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_exports();
    for (int k = 0; k < NREG; k++)
      chk(cfg_o[k*8 +: 8] == m_reg[k], "R11 cfg byte", {24'h0, cfg_o[k*8 +: 8]}, {24'h0, m_reg[k]});
    chk(nmi_vec_o == {m_reg[7], m_reg[6], m_reg[5], m_reg[4]}, "R6 vector", nmi_vec_o,
        {m_reg[7], m_reg[6], m_reg[5], m_reg[4]});
    chk(nmi_vec_en_o == m_reg[11][6], "R6 enable", {31'h0, nmi_vec_en_o}, {31'h0, m_reg[11][6]});
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    logic exp_upd = 1'b0;
    logic exp_sw  = 1'b0;
    case (a)
      16'h22: begin m_idx = d; m_arm = 1'b1; end
      16'h23: begin
        if (m_arm && f_impl(m_idx)) begin
          m_reg[m_idx - 8'h40] = d & f_mask(int'(m_idx - 8'h40));
          if (m_idx == 8'h4C) exp_upd = 1'b1;
        end
        m_arm = 1'b0;
      end
      16'h72: m_72 = d & 8'h7E;
      16'h7E: m_7e = d;
      16'h7F: begin
        m_7f = d;
        if (d[3] && m_reg[1][6]) begin exp_sw = 1'b1; model_reset(); end
      end
      default: ;
    endcase
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
    chk(map_upd_o == exp_upd, "R9 update strobe", {31'h0, map_upd_o}, {31'h0, exp_upd});
    chk(swrst_o == exp_sw, "R8 reset pulse", {31'h0, swrst_o}, {31'h0, exp_sw});
    chk_exports();
    @(negedge clk_i);
    chk(!map_upd_o && !swrst_o, "R8 R9 single cycle", {30'h0, map_upd_o, swrst_o}, 32'h0);
  endtask

  task automatic io_read(logic [15:0] a, string tag);
    logic [7:0] exp_d = 8'hFF;
    logic       exp_v = 1'b1;
    case (a)
      16'h22: exp_d = m_idx;
      16'h23: begin
        if (m_arm && f_impl(m_idx)) exp_d = m_reg[m_idx - 8'h40];
        m_arm = 1'b0;
      end
      16'h72: exp_d = m_72;
      16'h7E: exp_d = m_7e;
      16'h7F: exp_d = m_7f;
      default: exp_v = 1'b0;
    endcase
    @(negedge clk_i);
    io_addr_i = a; io_rd_i = 1'b1;
    @(negedge clk_i);
    io_rd_i = 1'b0;
    chk(io_rvalid_o == exp_v, {tag, " R10 valid"}, {31'h0, io_rvalid_o}, {31'h0, exp_v});
    if (exp_v) chk(io_rdata_o == exp_d, tag, {24'h0, io_rdata_o}, {24'h0, exp_d});
  endtask

  task automatic rd_idx(logic [7:0] ix, string tag);
    io_write(16'h22, ix);
    io_read(16'h23, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 reset state
    chk_exports();
    io_read(16'h22, "R5 R1 index after reset");
    io_read(16'h23, "R5 unarmed data read");
    for (int ix = 8'h40; ix <= 8'h4C; ix++) rd_idx(8'(ix), "R5 default");
    io_read(16'h72, "R5 port72"); io_read(16'h7E, "R5 port7e"); io_read(16'h7F, "R5 port7f");

    // R1 / R2 one-shot
    io_write(16'h22, 8'h43);
    io_read(16'h22, "R1 index readback");
    io_write(16'h23, 8'hA5);
    io_write(16'h23, 8'h5A);
    rd_idx(8'h43, "R2 second write ignored");
    io_read(16'h23, "R2 second read is FF");

    // R3 hole and out-of-bank
    io_write(16'h22, 8'h4A); io_write(16'h23, 8'h77);
    rd_idx(8'h4A, "R3 hole reads FF");
    io_write(16'h22, 8'h50); io_write(16'h23, 8'h77);
    rd_idx(8'h50, "R3 outside bank");
    rd_idx(8'h3F, "R3 below bank");

    // R4 masks
    for (int ix = 8'h40; ix <= 8'h4C; ix++) begin
      io_write(16'h22, 8'(ix)); io_write(16'h23, 8'hFF);
      rd_idx(8'(ix), "R4 mask");
    end

    // R6 vector
    io_write(16'h22, 8'h44); io_write(16'h23, 8'h11);
    io_write(16'h22, 8'h45); io_write(16'h23, 8'h22);
    io_write(16'h22, 8'h46); io_write(16'h23, 8'h33);
    io_write(16'h22, 8'h47); io_write(16'h23, 8'h44);
    io_write(16'h22, 8'h4B); io_write(16'h23, 8'h00);
    io_write(16'h22, 8'h4B); io_write(16'h23, 8'h40);

    // R7 aux ports
    io_write(16'h72, 8'hFF); io_read(16'h72, "R7 port72 mask");
    io_write(16'h7E, 8'hC3); io_read(16'h7E, "R7 port7e");

    // R8 without enable, then with enable
    io_write(16'h22, 8'h41); io_write(16'h23, 8'h00);
    io_write(16'h7F, 8'hFF); io_read(16'h7F, "R8 no reset without enable");
    io_write(16'h22, 8'h41); io_write(16'h23, 8'h40);
    io_write(16'h7F, 8'h08);
    io_read(16'h7F, "R8 port7f cleared"); io_read(16'h72, "R8 port72 cleared");
    io_read(16'h22, "R8 index cleared"); io_read(16'h23, "R8 flag cleared");
    rd_idx(8'h48, "R8 default restored");

    // R9 mapping strobe
    io_write(16'h22, 8'h4C); io_write(16'h23, 8'h9C);
    io_write(16'h23, 8'h11);

    // R10 undecoded
    io_read(16'h0024, "R10 undecoded");
    io_read(16'h0122, "R10 high address bits");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      logic [7:0] ix = 8'($urandom_range(8'h3E, 8'h4E));
      case (op)
        0, 1: io_write(16'h22, ix);
        2, 3: io_write(16'h23, d);
        4, 5: io_read(16'h23, "R2 R3 random data read");
        6:    io_write(($urandom_range(0, 1) != 0) ? 16'h72 : 16'h7E, d);
        7:    io_write(16'h7F, d);
        8:    io_read(16'h22 + 16'($urandom_range(0, 1)), "R1 random read");
        default: io_read(($urandom_range(0, 2) == 0) ? 16'h72 :
                         ($urandom_range(0, 1) != 0) ? 16'h7F : 16'h30, "R7 random aux read");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule